// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block renames a group of up to four instructions in a single clock cycle. Each instruction names up to two architectural source registers and at most one architectural destination. The block translates these names into physical register tags, taken from a table of 16 architectural registers mapped onto 128 physical registers. Every instruction that writes a register gets a fresh physical tag, drawn from a free-list interface. For each writer, the previous mapping of its destination is also reported, so that the reorder buffer can release that tag when the instruction commits.

Dependences inside a group are handled by comparators, so the group is never broken up into a sequence. A source that names a register written by an earlier slot of the same group takes the tag newly given to the nearest such slot, and does not use the table value. The same rule applies to the old mapping of a destination. When two slots write the same register, the later write is the one left in the table.

A group goes forward only if the free list offers at least as many tags as the group has writers. Otherwise the whole group is held back for that cycle and the table does not change. Renamed results appear on registered outputs one cycle after the group is accepted.

Top module: `rn_rename_stage`

## Requirements
- R1: While reset is high, the table is set so that architectural register i maps to physical tag i. In the cycle after reset, every out_valid bit is 0.
- R2: Consider a source of a valid slot for which no earlier valid writing slot in the same group names the same architectural register. That source gets the tag the table held before the group, that is, the state left by all previously accepted groups.
- R3: Consider a source of a valid slot for which one or more earlier valid writing slots in the group name the same architectural register. That source gets the new tag allocated to the highest-numbered of those slots.
- R4: Writing slots (in_valid and in_has_dst both 1) are counted in ascending slot order starting at 0. The k-th writer receives the tag in bits [7k+6:7k] of free_tags. In an accepted cycle, free_pop equals the number of writers.
- R5: For a writing slot, out_old is the tag of its destination from the nearest earlier writer of the same register in the group, or the table value if there is no such writer.
- R6: When several slots of one group write the same architectural register, later groups read the tag given to the highest-numbered of them.
- R7: A valid slot with in_has_dst 0 consumes no free tag and leaves the table unchanged. Its out_dst and out_old fields are 0. Every field of an invalid output slot is 0.
- R8: When the number of writers exceeds free_count, stall is 1 and free_pop is 0. In the next cycle all out_valid bits are 0, and the table is left unchanged.
- R9: An accepted group appears on the outputs in the cycle after the clock edge that accepts it. out_valid and out_has_dst follow the input flags of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Slot holds an instruction |
| in_has_dst | input | 4 | Slot writes a register |
| in_src0 | input | 16 | First source architectural register, 4 bits per slot |
| in_src1 | input | 16 | Second source architectural register, 4 bits per slot |
| in_dst | input | 16 | Destination architectural register, 4 bits per slot |
| free_count | input | 3 | Number of valid tags offered on free_tags (0 to 4) |
| free_tags | input | 28 | Offered free physical tags, 7 bits each, lowest first |
| stall | output | 1 | Group cannot be accepted this cycle |
| free_pop | output | 3 | Number of offered tags consumed this cycle |
| out_valid | output | 4 | Renamed slot valid |
| out_has_dst | output | 4 | Renamed slot writes a register |
| out_src0 | output | 28 | First source physical tag per slot |
| out_src1 | output | 28 | Second source physical tag per slot |
| out_dst | output | 28 | New destination physical tag per slot |
| out_old | output | 28 | Previous destination mapping per slot |

## Verification
The bench runs chains such as a slot that reads the destination of the slot just before it, and a source that two earlier slots both write. A block without bypassing would return stale table tags here, and one with the wrong priority would pick the farther writer. It writes the same register from two slots and then reads it in the next group; a table that kept the earlier write would expose this. It also mixes non-writing slots between writers, which catches an allocator that spends tags by slot position rather than by writer rank. Finally, it offers too few tags and then reads back registers that the stalled group named: a table updated during a stall would return the refused tags.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int RN_LANES     = 4;
  parameter int RN_ARCH_REGS = 16;
  parameter int RN_PHYS_REGS = 128;
  parameter int RN_SRCS      = 2;
endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int NA    = rn_pkg::RN_ARCH_REGS,
  parameter int NP    = rn_pkg::RN_PHYS_REGS,
  parameter int LANES = rn_pkg::RN_LANES,
  parameter int NRD   = 3 * LANES,
  localparam int AW   = $clog2(NA),
  localparam int PW   = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRD*AW-1:0] rd_idx,
  output logic [NRD*PW-1:0] rd_tag,
  input  logic [LANES-1:0]  wr_en,
  input  logic [LANES*AW-1:0] wr_idx,
  input  logic [LANES*PW-1:0] wr_tag
);
  logic [PW-1:0] map_q [NA];

  // later slots are written last, so they win on equal index
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < NA; a++) map_q[a] <= PW'(a);
    end else begin
      for (int s = 0; s < LANES; s++)
        if (wr_en[s]) map_q[wr_idx[s*AW +: AW]] <= wr_tag[s*PW +: PW];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_tag[r*PW +: PW] = map_q[rd_idx[r*AW +: AW]];
  end
endmodule

// File: rtl/rn_free_alloc.sv
module rn_free_alloc #(
  parameter int LANES = rn_pkg::RN_LANES,
  parameter int PW    = $clog2(rn_pkg::RN_PHYS_REGS),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]    writes,
  input  logic [CW-1:0]       free_count,
  input  logic [LANES*PW-1:0] free_tags,
  output logic [LANES*PW-1:0] new_tag,
  output logic                stall,
  output logic [CW-1:0]       pop
);
  logic [PW-1:0] offer [LANES];
  logic [CW-1:0] rank  [LANES];
  logic [CW-1:0] need;

  for (genvar k = 0; k < LANES; k++) begin : g_offer
    assign offer[k] = free_tags[k*PW +: PW];
  end

  // rank of each slot = number of writers in lower slots
  always_comb begin
    logic [CW-1:0] run;
    run = '0;
    for (int s = 0; s < LANES; s++) begin
      rank[s] = run;
      run     = run + CW'(writes[s]);
    end
    need = run;
  end

  for (genvar s = 0; s < LANES; s++) begin : g_pick
    assign new_tag[s*PW +: PW] = writes[s] ? offer[rank[s][CW-1:0] % LANES] : '0;
  end

  assign stall = (need > free_count);
  assign pop   = stall ? '0 : need;
endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
  parameter int LANES = rn_pkg::RN_LANES,
  parameter int AW    = $clog2(rn_pkg::RN_ARCH_REGS),
  parameter int PW    = $clog2(rn_pkg::RN_PHYS_REGS)
) (
  input  logic [LANES-1:0]    writes,
  input  logic [LANES*AW-1:0] src0,
  input  logic [LANES*AW-1:0] src1,
  input  logic [LANES*AW-1:0] dst,
  input  logic [LANES*PW-1:0] tbl_src0,
  input  logic [LANES*PW-1:0] tbl_src1,
  input  logic [LANES*PW-1:0] tbl_old,
  input  logic [LANES*PW-1:0] new_tag,
  output logic [LANES*PW-1:0] src0_tag,
  output logic [LANES*PW-1:0] src1_tag,
  output logic [LANES*PW-1:0] old_tag
);
  for (genvar s = 0; s < LANES; s++) begin : g_slot
    always_comb begin
      src0_tag[s*PW +: PW] = tbl_src0[s*PW +: PW];
      src1_tag[s*PW +: PW] = tbl_src1[s*PW +: PW];
      old_tag[s*PW +: PW]  = tbl_old[s*PW +: PW];
      // ascending scan: the nearest earlier writer overrides last
      for (int j = 0; j < s; j++) begin
        if (writes[j]) begin
          if (dst[j*AW +: AW] == src0[s*AW +: AW]) src0_tag[s*PW +: PW] = new_tag[j*PW +: PW];
          if (dst[j*AW +: AW] == src1[s*AW +: AW]) src1_tag[s*PW +: PW] = new_tag[j*PW +: PW];
          if (dst[j*AW +: AW] == dst[s*AW +: AW])  old_tag[s*PW +: PW]  = new_tag[j*PW +: PW];
        end
      end
    end
  end
endmodule

// File: rtl/rn_rename_stage.sv
module rn_rename_stage #(
  parameter int LANES = rn_pkg::RN_LANES,
  parameter int NA    = rn_pkg::RN_ARCH_REGS,
  parameter int NP    = rn_pkg::RN_PHYS_REGS,
  localparam int AW   = $clog2(NA),
  localparam int PW   = $clog2(NP),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES-1:0]    in_has_dst,
  input  logic [LANES*AW-1:0] in_src0,
  input  logic [LANES*AW-1:0] in_src1,
  input  logic [LANES*AW-1:0] in_dst,
  input  logic [CW-1:0]       free_count,
  input  logic [LANES*PW-1:0] free_tags,
  output logic                stall,
  output logic [CW-1:0]       free_pop,
  output logic [LANES-1:0]    out_valid,
  output logic [LANES-1:0]    out_has_dst,
  output logic [LANES*PW-1:0] out_src0,
  output logic [LANES*PW-1:0] out_src1,
  output logic [LANES*PW-1:0] out_dst,
  output logic [LANES*PW-1:0] out_old
);
  localparam int NRD = 3 * LANES;

  logic [LANES-1:0]    writes;
  logic [LANES-1:0]    take;
  logic [NRD*AW-1:0]   rd_idx;
  logic [NRD*PW-1:0]   rd_tag;
  logic [LANES*PW-1:0] new_tag;
  logic [LANES*PW-1:0] s0_tag, s1_tag, od_tag;

  assign writes = in_valid & in_has_dst;
  assign rd_idx = {in_dst, in_src1, in_src0};
  assign take   = in_valid & {LANES{~stall}};

  rn_free_alloc #(.LANES(LANES), .PW(PW)) u_alloc (
    .writes    (writes),
    .free_count(free_count),
    .free_tags (free_tags),
    .new_tag   (new_tag),
    .stall     (stall),
    .pop       (free_pop)
  );

  rn_alias_table #(.NA(NA), .NP(NP), .LANES(LANES), .NRD(NRD)) u_table (
    .clk   (clk),
    .rst   (rst),
    .rd_idx(rd_idx),
    .rd_tag(rd_tag),
    .wr_en (writes & take),
    .wr_idx(in_dst),
    .wr_tag(new_tag)
  );

  rn_dep_check #(.LANES(LANES), .AW(AW), .PW(PW)) u_dep (
    .writes  (writes),
    .src0    (in_src0),
    .src1    (in_src1),
    .dst     (in_dst),
    .tbl_src0(rd_tag[0 +: LANES*PW]),
    .tbl_src1(rd_tag[LANES*PW +: LANES*PW]),
    .tbl_old (rd_tag[2*LANES*PW +: LANES*PW]),
    .new_tag (new_tag),
    .src0_tag(s0_tag),
    .src1_tag(s1_tag),
    .old_tag (od_tag)
  );

  for (genvar s = 0; s < LANES; s++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[s]          <= 1'b0;
        out_has_dst[s]        <= 1'b0;
        out_src0[s*PW +: PW]  <= '0;
        out_src1[s*PW +: PW]  <= '0;
        out_dst[s*PW +: PW]   <= '0;
        out_old[s*PW +: PW]   <= '0;
      end else begin
        out_valid[s]          <= take[s];
        out_has_dst[s]        <= take[s] & in_has_dst[s];
        out_src0[s*PW +: PW]  <= take[s] ? s0_tag[s*PW +: PW] : '0;
        out_src1[s*PW +: PW]  <= take[s] ? s1_tag[s*PW +: PW] : '0;
        out_dst[s*PW +: PW]   <= (take[s] && in_has_dst[s]) ? new_tag[s*PW +: PW] : '0;
        out_old[s*PW +: PW]   <= (take[s] && in_has_dst[s]) ? od_tag[s*PW +: PW] : '0;
      end
    end
  end
endmodule

// File: rtl/rn_rename_checker.sv
module rn_rename_checker #(
  parameter int LANES = 4,
  parameter int AW    = 4,
  parameter int PW    = 7,
  parameter int CW    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [LANES-1:0]    in_valid,
  input logic [LANES-1:0]    in_has_dst,
  input logic [CW-1:0]       free_count,
  input logic                stall,
  input logic [CW-1:0]       free_pop,
  input logic [LANES-1:0]    out_valid,
  input logic [LANES-1:0]    out_has_dst,
  input logic [LANES*PW-1:0] out_dst,
  input logic [LANES*PW-1:0] out_old
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> out_valid == '0);

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> out_valid == '0);

  p_stall_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
    stall |-> free_pop == '0);

  p_stall_short_r8: assert property (@(posedge clk) disable iff (rst)
    stall |-> int'(free_count) < $countones(in_valid & in_has_dst));

  p_pop_count_r4: assert property (@(posedge clk) disable iff (rst)
    !stall |-> int'(free_pop) == $countones(in_valid & in_has_dst));

  p_flags_follow_r9: assert property (@(posedge clk) disable iff (rst)
    !stall |=> out_has_dst == $past(in_valid & in_has_dst));

  for (genvar s = 0; s < LANES; s++) begin : g_slot
    p_nodst_zero_r7: assert property (@(posedge clk) disable iff (rst)
      !out_has_dst[s] |-> (out_dst[s*PW +: PW] == '0 && out_old[s*PW +: PW] == '0));
  end
endmodule

bind rn_rename_stage rn_rename_checker #(
  .LANES(LANES), .AW(AW), .PW(PW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_has_dst (in_has_dst),
  .free_count (free_count),
  .stall      (stall),
  .free_pop   (free_pop),
  .out_valid  (out_valid),
  .out_has_dst(out_has_dst),
  .out_dst    (out_dst),
  .out_old    (out_old)
);

// File: tb/tb_rn_rename_stage.sv
`timescale 1ns/1ps
module tb_rn_rename_stage;
  localparam int L = 4, AW = 4, PW = 7, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [L-1:0] in_valid = '0, in_has_dst = '0;
  logic [L*AW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
  logic [CW-1:0] free_count = '0;
  logic [L*PW-1:0] free_tags = '0;
  logic stall;
  logic [CW-1:0] free_pop;
  logic [L-1:0] out_valid, out_has_dst;
  logic [L*PW-1:0] out_src0, out_src1, out_dst, out_old;

  rn_rename_stage dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int amap [16];
  int pool [$];
  int g_s0 [L], g_s1 [L], g_d [L];
  bit [L-1:0] g_v, g_h;
  string src_req = "R2";

  task automatic chk(int act, int exp, string req, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic apply(int fc);
    int lmap [16];
    int es0 [L], es1 [L], ed [L], eo [L];
    bit byp0 [L], byp1 [L];
    int need, k;
    bit est;
    if (fc > pool.size()) fc = pool.size();
    in_valid = g_v; in_has_dst = g_h; free_count = CW'(fc);
    for (int s = 0; s < L; s++) begin
      in_src0[s*AW +: AW] = AW'(g_s0[s]);
      in_src1[s*AW +: AW] = AW'(g_s1[s]);
      in_dst[s*AW +: AW]  = AW'(g_d[s]);
      free_tags[s*PW +: PW] = (s < fc) ? PW'(pool[s]) : '0;
    end
    need = 0;
    for (int s = 0; s < L; s++) if (g_v[s] && g_h[s]) need++;
    est = need > fc;
    // sequential reference: rename slots one after another
    lmap = amap; k = 0;
    for (int s = 0; s < L; s++) begin
      es0[s] = 0; es1[s] = 0; ed[s] = 0; eo[s] = 0; byp0[s] = 0; byp1[s] = 0;
      if (g_v[s]) begin
        es0[s] = lmap[g_s0[s]]; byp0[s] = lmap[g_s0[s]] != amap[g_s0[s]];
        es1[s] = lmap[g_s1[s]]; byp1[s] = lmap[g_s1[s]] != amap[g_s1[s]];
        if (g_h[s]) begin
          eo[s] = lmap[g_d[s]];
          ed[s] = (k < fc) ? pool[k] : 0;
          lmap[g_d[s]] = ed[s];
          k++;
        end
      end
    end
    #1;
    chk(int'(stall), int'(est), "R8", "stall");
    chk(int'(free_pop), est ? 0 : need, est ? "R8" : "R4", "free_pop");
    @(posedge clk); @(negedge clk);
    for (int s = 0; s < L; s++) begin
      bit ok = g_v[s] && !est;
      chk(int'(out_valid[s]), int'(ok), est ? "R8" : "R9", $sformatf("out_valid[%0d]", s));
      chk(int'(out_has_dst[s]), int'(ok && g_h[s]), "R9", $sformatf("out_has_dst[%0d]", s));
      chk(int'(out_src0[s*PW +: PW]), ok ? es0[s] : 0, byp0[s] ? "R3" : src_req, $sformatf("src0[%0d]", s));
      chk(int'(out_src1[s*PW +: PW]), ok ? es1[s] : 0, byp1[s] ? "R3" : src_req, $sformatf("src1[%0d]", s));
      chk(int'(out_dst[s*PW +: PW]), (ok && g_h[s]) ? ed[s] : 0, g_h[s] ? "R4" : "R7", $sformatf("dst[%0d]", s));
      chk(int'(out_old[s*PW +: PW]), (ok && g_h[s]) ? eo[s] : 0, g_h[s] ? "R5" : "R7", $sformatf("old[%0d]", s));
    end
    if (!est) begin
      for (int s = 0; s < L; s++)
        if (g_v[s] && g_h[s]) begin
          void'(pool.pop_front());
          pool.push_back(eo[s]);
        end
      amap = lmap;
    end
  endtask

  task automatic set_slot(int s, bit v, bit h, int a, int b, int d);
    g_v[s] = v; g_h[s] = h; g_s0[s] = a; g_s1[s] = b; g_d[s] = d;
  endtask

  initial begin
    #1600000;
    $display("FAIL watchdog actual=timeout expected=done");
    bad++; total++;
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) amap[i] = i;
    for (int p = 16; p < 128; p++) pool.push_back(p);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(int'(out_valid), 0, "R1", "out_valid after reset");
    // R1: identity mapping read back through sources
    src_req = "R1";
    for (int s = 0; s < L; s++) set_slot(s, 1, 0, s, s + 4, 0);
    apply(4);
    for (int s = 0; s < L; s++) set_slot(s, 1, 0, s + 8, s + 12, 0);
    apply(0);
    // dependent chain, R3 / R5
    src_req = "R2";
    set_slot(0, 1, 1, 1, 2, 3);
    set_slot(1, 1, 1, 3, 4, 5);
    set_slot(2, 1, 1, 6, 7, 8);
    set_slot(3, 1, 1, 8, 8, 9);
    apply(4);
    // triple writers of one register, nearest wins; R6 checked next group
    set_slot(0, 1, 1, 2, 2, 2);
    set_slot(1, 1, 1, 2, 0, 2);
    set_slot(2, 1, 0, 2, 2, 0);
    set_slot(3, 1, 1, 2, 1, 2);
    apply(4);
    src_req = "R6";
    for (int s = 0; s < L; s++) set_slot(s, 1, 0, 2, 3, 0);
    apply(0);
    // R7: non-writers between writers, gaps in valid
    src_req = "R2";
    set_slot(0, 1, 0, 5, 6, 7);
    set_slot(1, 0, 1, 5, 6, 7);
    set_slot(2, 1, 1, 7, 5, 10);
    set_slot(3, 1, 0, 10, 7, 11);
    apply(1);
    // R8: too few tags, then read back the named registers
    for (int s = 0; s < L; s++) set_slot(s, 1, 1, s, s, 12 + s);
    apply(3);
    src_req = "R8";
    for (int s = 0; s < L; s++) set_slot(s, 1, 0, 12 + s, s, 0);
    apply(2);
    // idle group
    src_req = "R2";
    for (int s = 0; s < L; s++) set_slot(s, 0, 0, 0, 0, 0);
    apply(4);
    // mixed random groups
    for (int n = 0; n < 400; n++) begin
      for (int s = 0; s < L; s++)
        set_slot(s, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
                 $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));
      apply($urandom_range(0, 4));
    end
    finish_run();
  end
endmodule